// File: doc/BRIEF.md
# Systolic Hankel Matrix-Vector Multiplier over GF(2)

This block multiplies a D×D matrix over GF(2) by a D-bit vector, where the matrix has the Hankel property: every entry on one anti-diagonal has the same value. A single generating word `h` of 2D−1 bits therefore describes the whole matrix, with entry (i, j) equal to `h[i+j]`. The product bit `c[i]` is the XOR over all j of `h[i+j] AND b[j]`. Arithmetic is carry-free: multiplication is AND and addition is XOR.

The datapath is a pipelined array of one-bit AND-XOR cells. An input register captures `h` and `b`. D stages follow, and each stage folds in one vector bit. The stages take the vector bits from the most significant, `b[D-1]`, down to `b[0]`. Each cell reads its matrix bit from the lower half of `h` (index below D) or from the upper half, according to where its anti-diagonal falls. A new operand pair may enter on every clock cycle. The block is meant to sit inside a larger digit-serial finite-field multiplier that formats the operands and accumulates the partial products outside it.

Top module: `hankel_systolic`

## Requirements
- R1: When `out_valid` is high, `c[i]` equals the XOR over j = 0..D−1 of `h[i+j] & b[j]`. Bit 0 of `h` and bit 0 of `b` are the least significant, and `h`, `b` are the values that were accepted with that transaction.
- R2: An operand pair accepted with `in_valid` high at a rising edge makes `out_valid` high for exactly one cycle. `out_valid` rises after the D+1-th rising edge, counting the accepting edge as the first.
- R3: Operand pairs accepted on consecutive cycles each produce their own result on consecutive cycles, with no bubbles and no mixing between them.
- R4: While `rst` (synchronous, active high) is sampled high, the next edge drives `out_valid` to 0 and `c` to all zeros.
- R5: Whenever `out_valid` is low, `c` is all zeros. A cycle with `in_valid` low produces such an empty output slot D+1 cycles later.
- R6: Operand pairs accepted before a reset never produce `out_valid` after the reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair on `h` and `b` is presented this cycle |
| h | input | 2D−1 | Generating word of the Hankel matrix, entry (i, j) = h[i+j] |
| b | input | D | Vector operand |
| out_valid | output | 1 | `c` carries a finished product |
| c | output | D | Product vector, zero while `out_valid` is low |

## Verification
Every result is due D+1 rising edges after the edge that accepts its operands: one edge for the input register and one for each of the D stages. The bench drives operands just after a falling edge. It records each expected result in a ring indexed by the drive cycle, and reads the outputs at the falling edge D+1 cycles later, away from the active edge. Instances with D = 2, 4 and 8 each run against their own delay. A lone pulse confirms that `out_valid` is low one cycle early and one cycle late. After a reset issued with operands still in flight, the bench watches more than D+1 cycles to confirm that no result emerges.

// File: rtl/hankel_pkg.sv
package hankel_pkg;

    // Which half of the generating word a cell taps.
    typedef enum logic {
        TAP_LOW  = 1'b0,   // anti-diagonal index below D
        TAP_HIGH = 1'b1    // anti-diagonal index D or above
    } tap_kind_e;

    // Width of the generating word for a D x D Hankel matrix.
    function automatic int gen_width(input int dim);
        return 2 * dim - 1;
    endfunction

    // Column (vector bit) consumed by a pipeline stage: most significant first.
    function automatic int col_of_stage(input int stage, input int dim);
        return dim - 1 - stage;
    endfunction

    // Cell flavour for matrix entry (row, col).
    function automatic tap_kind_e tap_kind(input int row, input int col, input int dim);
        return (row + col < dim) ? TAP_LOW : TAP_HIGH;
    endfunction

    // Bit offset inside the selected half of the generating word.
    function automatic int tap_offset(input int row, input int col, input int dim);
        return (row + col < dim) ? (row + col) : (row + col - dim);
    endfunction

endpackage

// File: rtl/hankel_cell.sv
module hankel_cell
    import hankel_pkg::*;
#(
    parameter int D   = 8,
    parameter int ROW = 0,
    parameter int COL = 0
) (
    input  logic [D-1:0] gen_lo,
    input  logic [D-2:0] gen_hi,
    input  logic         vec_bit,
    input  logic         psum_in,
    output logic         psum_out
);

    localparam tap_kind_e KIND = tap_kind(ROW, COL, D);
    localparam int        OFS  = tap_offset(ROW, COL, D);

    logic mat_bit;
    logic unused_taps;

    generate
        if (KIND == TAP_LOW) begin : g_low
            assign mat_bit = gen_lo[OFS];
        end else begin : g_high
            assign mat_bit = gen_hi[OFS];
        end
    endgenerate

    // Bits of the generating word that this cell does not tap.
    assign unused_taps = ^{gen_lo, gen_hi};

    // One GF(2) multiply-accumulate: AND then XOR.
    assign psum_out = psum_in ^ (vec_bit & mat_bit);

endmodule

// File: rtl/hankel_stage.sv
module hankel_stage
    import hankel_pkg::*;
#(
    parameter int D     = 8,
    parameter int STAGE = 0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [gen_width(D)-1:0] in_gen,
    input  logic [D-1:0]            in_vec,
    input  logic [D-1:0]            in_acc,
    output logic                    out_valid,
    output logic [gen_width(D)-1:0] out_gen,
    output logic [D-1:0]            out_vec,
    output logic [D-1:0]            out_acc
);

    localparam int GW  = gen_width(D);
    localparam int COL = col_of_stage(STAGE, D);

    typedef struct packed {
        logic          valid;
        logic [GW-1:0] gen;
        logic [D-1:0]  vec;
        logic [D-1:0]  acc;
    } slot_t;

    slot_t        slot_q;
    slot_t        slot_d;
    logic [D-1:0] acc_next;

    // One column of cells: every row folds in vector bit COL.
    generate
        for (genvar r = 0; r < D; r++) begin : g_row
            hankel_cell #(
                .D   (D),
                .ROW (r),
                .COL (COL)
            ) u_cell (
                .gen_lo   (in_gen[D-1:0]),
                .gen_hi   (in_gen[GW-1:D]),
                .vec_bit  (in_vec[COL]),
                .psum_in  (in_acc[r]),
                .psum_out (acc_next[r])
            );
        end
    endgenerate

    // Empty slots travel as all-zero words.
    always_comb begin
        slot_d = '0;
        if (in_valid) begin
            slot_d.valid = 1'b1;
            slot_d.gen   = in_gen;
            slot_d.vec   = in_vec;
            slot_d.acc   = acc_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign out_valid = slot_q.valid;
    assign out_gen   = slot_q.gen;
    assign out_vec   = slot_q.vec;
    assign out_acc   = slot_q.acc;

endmodule

// File: rtl/hankel_systolic.sv
module hankel_systolic
    import hankel_pkg::*;
#(
    parameter int D = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [gen_width(D)-1:0] h,
    input  logic [D-1:0]            b,
    output logic                    out_valid,
    output logic [D-1:0]            c
);

    localparam int GW = gen_width(D);

    typedef struct packed {
        logic          valid;
        logic [GW-1:0] gen;
        logic [D-1:0]  vec;
    } front_t;

    front_t front_q;

    // Chain index 0 is the input register; index s+1 is the output of stage s.
    logic [D:0]    v_chain;
    logic [GW-1:0] g_chain [D+1];
    logic [D-1:0]  b_chain [D+1];
    logic [D-1:0]  a_chain [D+1];
    logic          unused_tail;

    always_ff @(posedge clk) begin
        if (rst) begin
            front_q <= '0;
        end else if (in_valid) begin
            front_q.valid <= 1'b1;
            front_q.gen   <= h;
            front_q.vec   <= b;
        end else begin
            front_q <= '0;
        end
    end

    assign v_chain[0] = front_q.valid;
    assign g_chain[0] = front_q.gen;
    assign b_chain[0] = front_q.vec;
    assign a_chain[0] = '0;

    generate
        for (genvar s = 0; s < D; s++) begin : g_stage
            hankel_stage #(
                .D     (D),
                .STAGE (s)
            ) u_stage (
                .clk       (clk),
                .rst       (rst),
                .in_valid  (v_chain[s]),
                .in_gen    (g_chain[s]),
                .in_vec    (b_chain[s]),
                .in_acc    (a_chain[s]),
                .out_valid (v_chain[s+1]),
                .out_gen   (g_chain[s+1]),
                .out_vec   (b_chain[s+1]),
                .out_acc   (a_chain[s+1])
            );
        end
    endgenerate

    // The operands are no longer needed once the last stage has them.
    assign unused_tail = ^{g_chain[D], b_chain[D]};

    assign out_valid = v_chain[D];
    assign c         = a_chain[D];

endmodule

// File: rtl/hankel_systolic_chk.sv
module hankel_systolic_chk
    import hankel_pkg::*;
#(
    parameter int D = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic [gen_width(D)-1:0] h,
    input logic [D-1:0]            b,
    input logic                    out_valid,
    input logic [D-1:0]            c
);

    localparam int GW = gen_width(D);

    logic          dv [D+1];
    logic [GW-1:0] dh [D+1];
    logic [D-1:0]  db [D+1];
    logic [D-1:0]  ref_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k <= D; k++) begin
                dv[k] <= 1'b0;
                dh[k] <= '0;
                db[k] <= '0;
            end
        end else begin
            dv[0] <= in_valid;
            dh[0] <= h;
            db[0] <= b;
            for (int k = 1; k <= D; k++) begin
                dv[k] <= dv[k-1];
                dh[k] <= dh[k-1];
                db[k] <= db[k-1];
            end
        end
    end

    always_comb begin
        ref_c = '0;
        for (int i = 0; i < D; i++) begin
            for (int j = 0; j < D; j++) begin
                ref_c[i] = ref_c[i] ^ (dh[D][i+j] & db[D][j]);
            end
        end
    end

    assert_product_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (c == ref_c));

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid == dv[D]);

    assert_reset_clears_R4: assert property (@(posedge clk)
        rst |=> (!out_valid && (c == '0)));

    assert_empty_slot_zero_R5: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (c == '0));

    assert_flush_R6: assert property (@(posedge clk)
        $fell(rst) |-> !out_valid);

endmodule

bind hankel_systolic hankel_systolic_chk #(.D(D)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .h         (h),
    .b         (b),
    .out_valid (out_valid),
    .c         (c)
);

// File: tb/hankel_systolic_test.sv
`timescale 1ns/1ps
module hankel_systolic_test;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst;
    logic [14:0] hs [3];
    logic [7:0]  bs [3];
    logic        vs [3];
    logic        ov [3];
    logic [1:0]  c2;
    logic [3:0]  c4;
    logic [7:0]  c8;

    hankel_systolic #(.D(2)) uut_d2 (
        .clk(clk), .rst(rst), .in_valid(vs[0]), .h(hs[0][2:0]), .b(bs[0][1:0]),
        .out_valid(ov[0]), .c(c2));

    hankel_systolic #(.D(4)) uut_d4 (
        .clk(clk), .rst(rst), .in_valid(vs[1]), .h(hs[1][6:0]), .b(bs[1][3:0]),
        .out_valid(ov[1]), .c(c4));

    hankel_systolic #(.D(8)) uut (
        .clk(clk), .rst(rst), .in_valid(vs[2]), .h(hs[2]), .b(bs[2]),
        .out_valid(ov[2]), .c(c8));

    // {h[14:0], b[7:0], expected c[7:0]} for D = 8
    localparam logic [30:0] TABLE [12] = '{
        {15'h0000, 8'hFF, 8'h00},
        {15'h7FFF, 8'h01, 8'hFF},
        {15'h0001, 8'h01, 8'h01},
        {15'h0001, 8'hFF, 8'h01},
        {15'h4000, 8'h80, 8'h80},
        {15'h4000, 8'h7F, 8'h00},
        {15'h0100, 8'hFF, 8'hFE},
        {15'h0100, 8'h02, 8'h80},
        {15'h7FFF, 8'hFF, 8'h00},
        {15'h7FFF, 8'h07, 8'hFF},
        {15'h5555, 8'h01, 8'h55},
        {15'h5555, 8'h03, 8'hFF}
    };

    int n_checks = 0;
    int n_bad    = 0;
    bit finished = 0;

    logic [7:0] ring_c [3][16];
    logic       ring_v [3][16];

    function automatic int dim_of(input int k);
        return (k == 0) ? 2 : ((k == 1) ? 4 : 8);
    endfunction

    function automatic logic [7:0] out_of(input int k);
        case (k)
            0:       return {6'b0, c2};
            1:       return {4'b0, c4};
            default: return c8;
        endcase
    endfunction

    function automatic logic [7:0] ref_mul(input int d, input logic [14:0] hh, input logic [7:0] bb);
        logic [7:0] r = '0;
        for (int i = 0; i < d; i++)
            for (int j = 0; j < d; j++)
                r[i] = r[i] ^ (hh[i+j] & bb[j]);
        return r;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle_all();
        for (int k = 0; k < 3; k++) begin
            vs[k] = 1'b0;
            hs[k] = '0;
            bs[k] = '0;
        end
    endtask

    initial begin
        rst = 1'b1;
        idle_all();
        repeat (3) @(negedge clk);
        // R4: outputs cleared while reset is held
        chk("R4 out_valid", {15'b0, ov[2]}, 16'h0);
        chk("R4 c", {8'b0, c8}, 16'h0);
        chk("R4 out_valid d2", {15'b0, ov[0]}, 16'h0);
        rst = 1'b0;

        // R1 and R3: table entries streamed back to back into the D=8 instance
        for (int m = 0; m < 12 + 9; m++) begin
            @(negedge clk);
            if (m >= 9) begin
                chk("R1 table c", {8'b0, c8}, {8'b0, TABLE[m-9][7:0]});
                chk("R3 table out_valid", {15'b0, ov[2]}, 16'h1);
            end
            if (m < 12) begin
                vs[2] = 1'b1;
                hs[2] = TABLE[m][30:16];
                bs[2] = TABLE[m][15:8];
            end else begin
                idle_all();
            end
        end
        repeat (3) @(negedge clk);

        // R2: a lone operand pair emerges after exactly D+1 edges
        for (int m = 0; m <= 10; m++) begin
            @(negedge clk);
            if (m >= 1 && m <= 8) chk("R2 early out_valid", {15'b0, ov[2]}, 16'h0);
            if (m == 9) begin
                chk("R2 on-time out_valid", {15'b0, ov[2]}, 16'h1);
                chk("R2 on-time c", {8'b0, c8}, 16'h00FF);
            end
            if (m == 10) chk("R2 late out_valid", {15'b0, ov[2]}, 16'h0);
            if (m == 0) begin
                vs[2] = 1'b1;
                hs[2] = 15'h7FFF;
                bs[2] = 8'h01;
            end else begin
                idle_all();
            end
        end

        // R1, R3, R5: random stream with bubbles into D = 2, 4, 8
        for (int m = 0; m < 400; m++) begin
            @(negedge clk);
            for (int k = 0; k < 3; k++) begin
                int d;
                d = dim_of(k);
                if (m >= d + 1) begin
                    int slot;
                    slot = (m - d - 1) & 15;
                    if (ring_v[k][slot]) begin
                        chk("R1 stream c", {8'b0, out_of(k)}, {8'b0, ring_c[k][slot]});
                        chk("R3 stream out_valid", {15'b0, ov[k]}, 16'h1);
                    end else begin
                        chk("R5 bubble c", {8'b0, out_of(k)}, 16'h0);
                        chk("R5 bubble out_valid", {15'b0, ov[k]}, 16'h0);
                    end
                end
            end
            for (int k = 0; k < 3; k++) begin
                int d;
                logic v;
                d = dim_of(k);
                v = (($urandom % 4) != 0);
                vs[k] = v;
                hs[k] = 15'($urandom) & 15'((1 << (2 * d - 1)) - 1);
                bs[k] = 8'($urandom) & 8'((1 << d) - 1);
                ring_v[k][m & 15] = v;
                ring_c[k][m & 15] = v ? ref_mul(d, hs[k], bs[k]) : 8'h00;
            end
        end
        @(negedge clk);
        idle_all();
        repeat (12) @(negedge clk);

        // R6: operands in flight at reset never emerge
        for (int m = 0; m < 16; m++) begin
            @(negedge clk);
            if (m >= 4) begin
                for (int k = 0; k < 3; k++) begin
                    chk("R6 flushed out_valid", {15'b0, ov[k]}, 16'h0);
                    chk("R6 flushed c", {8'b0, out_of(k)}, 16'h0);
                end
            end
            if (m < 3) begin
                for (int k = 0; k < 3; k++) begin
                    vs[k] = 1'b1;
                    hs[k] = 15'h7FFF;
                    bs[k] = 8'h01;
                end
            end else begin
                idle_all();
            end
            rst = (m == 3);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

endmodule